// File: doc/BRIEF.md
# Channel Bit Command Port

This block is a write-only command port for a multi-channel engine. It turns single-byte writes into bit operations on five per-channel vectors: an error-interrupt enable vector, an interrupt request vector, an error flag vector, a start vector and a done vector. Each write gives a command-select code and one data byte. For the channel commands, the byte carries a no-operation flag in bit 7 and a 7-bit channel field in bits 6..0. The field names one channel, names all channels, or falls in a reserved range that does nothing.

The engine's own hardware events also drive the vectors. Per-channel inputs set interrupt, error and done bits and clear start bits. If a hardware event and a command reach the same bit in the same cycle, the set wins. Every command write changes state on the clock edge that samples the strobe. On that same edge the block registers one-cycle pulse vectors that show which bits the command asked to set or clear. Software reads of the vectors go through logic outside this block.

Top module: `ccp_cmd_port`

## Requirements
- R1: After reset every vector output and every pulse output is zero.
- R2: A channel command whose data bit 7 is 1 changes no vector and raises no pulse, whatever bits 6..0 hold.
- R3: A channel command with bits 7..0 in 0..15 acts only on the bit of that channel.
- R4: A channel command with bits 7..0 in 16..63 changes no vector and raises no pulse.
- R5: A channel command with bits 7..0 in 64..127 acts on all 16 bits of its target vector at once.
- R6: The select codes are 0 = set error-interrupt enable, 1 = clear error-interrupt enable, 2 = clear interrupt request, 3 = clear error flag, 4 = set start, 5 = clear done. Each code touches only its own vector.
- R7: Select codes 6 and 7 clear interrupt request bits 7..0 and 15..8 wherever the data byte holds a 1. Codes 8 and 9 do the same for error flag bits 7..0 and 15..8.
- R8: Select codes 10 to 15 change no vector and raise no pulse.
- R9: A hardware set on a bit wins over a command clear of that bit in the same cycle. A start set command wins over a hardware start clear of the same bit in the same cycle.
- R10: A command changes its vector on the clock edge that samples the write strobe and not before. Its pulse output is high for exactly the cycle after that edge.
- R11: The inputs hw_int_set, hw_err_set and hw_done_set set their bits, and hw_start_clr clears start bits, on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command write strobe |
| cmd_sel | input | 4 | Command-select code |
| wr_data | input | 8 | Command data byte |
| hw_int_set | input | 16 | Hardware interrupt request set per channel |
| hw_err_set | input | 16 | Hardware error flag set per channel |
| hw_done_set | input | 16 | Hardware done set per channel |
| hw_start_clr | input | 16 | Hardware start clear per channel |
| eei_o | output | 16 | Error-interrupt enable vector |
| int_o | output | 16 | Interrupt request vector |
| err_o | output | 16 | Error flag vector |
| start_o | output | 16 | Start vector |
| done_o | output | 16 | Done vector |
| eei_set_p | output | 16 | Enable set pulse |
| eei_clr_p | output | 16 | Enable clear pulse |
| int_clr_p | output | 16 | Interrupt request clear pulse |
| err_clr_p | output | 16 | Error flag clear pulse |
| start_set_p | output | 16 | Start set pulse |
| done_clr_p | output | 16 | Done clear pulse |

## Verification
The assertions run on every cycle. They check that a set always lands, even when a clear hits the same bit. They check that an uncontested clear removes its bits and that a vector holds when nothing acts on it. They also check that no-operation bytes, reserved channel codes and idle cycles raise no pulse, and that a single-channel command raises exactly one pulse bit.

Only the bench scenarios can show the rest. That covers the mapping of each select code to its own vector and the all-channel form. It also covers the byte lanes of the write-one-to-clear codes and the silence of the unused select codes. Finally, the bench shows that the vectors do not change before the sampling edge.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    // Command-select codes; the value is the code on cmd_sel
    typedef enum logic [3:0] {
        OP_EEI_SET    = 4'd0,
        OP_EEI_CLR    = 4'd1,
        OP_INT_CLR    = 4'd2,
        OP_ERR_CLR    = 4'd3,
        OP_START_SET  = 4'd4,
        OP_DONE_CLR   = 4'd5,
        OP_INT_W1C_LO = 4'd6,
        OP_INT_W1C_HI = 4'd7,
        OP_ERR_W1C_LO = 4'd8,
        OP_ERR_W1C_HI = 4'd9
    } op_e;

    localparam int DATA_W   = 8;
    localparam int FIELD_W  = 7;
    localparam int NOP_BIT  = 7;
    localparam int ALL_BIT  = 6;
    localparam int LANE_W   = 8;

endpackage

// File: rtl/ccp_chan_decode.sv
module ccp_chan_decode #(
    parameter int NCH = 16
) (
    input  logic [ccp_pkg::DATA_W-1:0] cmd_byte,
    output logic [NCH-1:0]             chan_mask
);
    import ccp_pkg::*;

    logic                nop;
    logic                all_ch;
    logic [FIELD_W-1:0]  field;

    assign nop    = cmd_byte[NOP_BIT];
    assign all_ch = cmd_byte[ALL_BIT];
    assign field  = cmd_byte[FIELD_W-1:0];

    // Codes from NCH up to 63 match no channel and so act as reserved
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            chan_mask[i] = !nop && (all_ch || (field == FIELD_W'(i)));
        end
    end

    always_comb begin
        if (cmd_byte[NOP_BIT]) begin
            AST_NOP_EMPTY: assert (chan_mask == '0); // R2
        end
    end

endmodule

// File: rtl/ccp_vec_reg.sv
module ccp_vec_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_d, q_q;

    // Set takes priority over clear on the same bit
    always_comb begin
        q_d = (q_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q_o = q_q;

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i))); // R9
    AST_CLR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0)); // R10
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i == '0) && (clr_i == '0)) |=> $stable(q_o)); // R10

endmodule

// File: rtl/ccp_cmd_port.sv
module ccp_cmd_port #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [3:0]     cmd_sel,
    input  logic [7:0]     wr_data,
    input  logic [NCH-1:0] hw_int_set,
    input  logic [NCH-1:0] hw_err_set,
    input  logic [NCH-1:0] hw_done_set,
    input  logic [NCH-1:0] hw_start_clr,
    output logic [NCH-1:0] eei_o,
    output logic [NCH-1:0] int_o,
    output logic [NCH-1:0] err_o,
    output logic [NCH-1:0] start_o,
    output logic [NCH-1:0] done_o,
    output logic [NCH-1:0] eei_set_p,
    output logic [NCH-1:0] eei_clr_p,
    output logic [NCH-1:0] int_clr_p,
    output logic [NCH-1:0] err_clr_p,
    output logic [NCH-1:0] start_set_p,
    output logic [NCH-1:0] done_clr_p
);
    import ccp_pkg::*;

    typedef struct packed {
        logic [NCH-1:0] eei_set;
        logic [NCH-1:0] eei_clr;
        logic [NCH-1:0] int_clr;
        logic [NCH-1:0] err_clr;
        logic [NCH-1:0] start_set;
        logic [NCH-1:0] done_clr;
    } pulse_t;

    pulse_t         pls_d, pls_q;
    logic [NCH-1:0] chan_mask;
    logic [NCH-1:0] lane_lo, lane_hi;

    ccp_chan_decode #(.NCH(NCH)) u_dec (
        .cmd_byte  (wr_data),
        .chan_mask (chan_mask)
    );

    // Byte-lane masks for the write-one-to-clear codes
    for (genvar i = 0; i < NCH; i++) begin : g_lane
        if (i < LANE_W) begin : g_lo
            assign lane_lo[i] = wr_data[i % LANE_W];
            assign lane_hi[i] = 1'b0;
        end else if (i < 2 * LANE_W) begin : g_hi
            assign lane_lo[i] = 1'b0;
            assign lane_hi[i] = wr_data[i % LANE_W];
        end else begin : g_none
            assign lane_lo[i] = 1'b0;
            assign lane_hi[i] = 1'b0;
        end
    end

    always_comb begin
        pls_d = '0;
        if (wr_en) begin
            case (cmd_sel)
                OP_EEI_SET:    pls_d.eei_set   = chan_mask;
                OP_EEI_CLR:    pls_d.eei_clr   = chan_mask;
                OP_INT_CLR:    pls_d.int_clr   = chan_mask;
                OP_ERR_CLR:    pls_d.err_clr   = chan_mask;
                OP_START_SET:  pls_d.start_set = chan_mask;
                OP_DONE_CLR:   pls_d.done_clr  = chan_mask;
                OP_INT_W1C_LO: pls_d.int_clr   = lane_lo;
                OP_INT_W1C_HI: pls_d.int_clr   = lane_hi;
                OP_ERR_W1C_LO: pls_d.err_clr   = lane_lo;
                OP_ERR_W1C_HI: pls_d.err_clr   = lane_hi;
                default:       pls_d           = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pls_q <= '0;
        else        pls_q <= pls_d;
    end

    ccp_vec_reg #(.W(NCH)) u_eei (
        .clk(clk), .rst_n(rst_n),
        .set_i(pls_d.eei_set), .clr_i(pls_d.eei_clr), .q_o(eei_o));
    ccp_vec_reg #(.W(NCH)) u_int (
        .clk(clk), .rst_n(rst_n),
        .set_i(hw_int_set), .clr_i(pls_d.int_clr), .q_o(int_o));
    ccp_vec_reg #(.W(NCH)) u_err (
        .clk(clk), .rst_n(rst_n),
        .set_i(hw_err_set), .clr_i(pls_d.err_clr), .q_o(err_o));
    ccp_vec_reg #(.W(NCH)) u_start (
        .clk(clk), .rst_n(rst_n),
        .set_i(pls_d.start_set), .clr_i(hw_start_clr), .q_o(start_o));
    ccp_vec_reg #(.W(NCH)) u_done (
        .clk(clk), .rst_n(rst_n),
        .set_i(hw_done_set), .clr_i(pls_d.done_clr), .q_o(done_o));

    assign eei_set_p   = pls_q.eei_set;
    assign eei_clr_p   = pls_q.eei_clr;
    assign int_clr_p   = pls_q.int_clr;
    assign err_clr_p   = pls_q.err_clr;
    assign start_set_p = pls_q.start_set;
    assign done_clr_p  = pls_q.done_clr;

    logic [NCH-1:0] any_pulse;
    assign any_pulse = eei_set_p | eei_clr_p | int_clr_p | err_clr_p
                     | start_set_p | done_clr_p;

    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7] && (cmd_sel < 4'd6)) |=> (any_pulse == '0)); // R2
    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[7] && !wr_data[6] && (32'(wr_data[6:0]) >= NCH)
         && (cmd_sel < 4'd6)) |=> (any_pulse == '0)); // R4
    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[7] && (32'(wr_data[6:0]) < NCH) && (cmd_sel < 4'd6))
        |=> $onehot(any_pulse)); // R3
    AST_SEL_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (cmd_sel > 4'd9)) |=> (any_pulse == '0)); // R8
    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (any_pulse == '0)); // R10

endmodule

// File: tb/sim_ccp_cmd_port.sv
`timescale 1ns/1ps
module sim_ccp_cmd_port;
    localparam int NCH = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [3:0]     cmd_sel = '0;
    logic [7:0]     wr_data = '0;
    logic [NCH-1:0] hw_int_set = '0, hw_err_set = '0, hw_done_set = '0, hw_start_clr = '0;
    logic [NCH-1:0] eei_o, int_o, err_o, start_o, done_o;
    logic [NCH-1:0] eei_set_p, eei_clr_p, int_clr_p, err_clr_p, start_set_p, done_clr_p;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ccp_cmd_port #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd_sel(cmd_sel), .wr_data(wr_data),
        .hw_int_set(hw_int_set), .hw_err_set(hw_err_set), .hw_done_set(hw_done_set),
        .hw_start_clr(hw_start_clr),
        .eei_o(eei_o), .int_o(int_o), .err_o(err_o), .start_o(start_o), .done_o(done_o),
        .eei_set_p(eei_set_p), .eei_clr_p(eei_clr_p), .int_clr_p(int_clr_p),
        .err_clr_p(err_clr_p), .start_set_p(start_set_p), .done_clr_p(done_clr_p));

    task automatic chk(input string req, input string what,
                       input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] pulses();
        return eei_set_p | eei_clr_p | int_clr_p | err_clr_p | start_set_p | done_clr_p;
    endfunction

    // Drive one command (plus optional hardware events) at a negedge;
    // on return the sampling edge has passed and the pulses are visible.
    task automatic cmd(input logic [3:0] sel, input logic [7:0] data,
                       input logic [NCH-1:0] hi = '0, input logic [NCH-1:0] he = '0,
                       input logic [NCH-1:0] hd = '0, input logic [NCH-1:0] hs = '0);
        @(negedge clk);
        wr_en = 1'b1; cmd_sel = sel; wr_data = data;
        hw_int_set = hi; hw_err_set = he; hw_done_set = hd; hw_start_clr = hs;
        @(negedge clk);
        wr_en = 1'b0; cmd_sel = '0; wr_data = '0;
        hw_int_set = '0; hw_err_set = '0; hw_done_set = '0; hw_start_clr = '0;
    endtask

    task automatic hw(input logic [NCH-1:0] hi, input logic [NCH-1:0] he,
                      input logic [NCH-1:0] hd, input logic [NCH-1:0] hs);
        @(negedge clk);
        hw_int_set = hi; hw_err_set = he; hw_done_set = hd; hw_start_clr = hs;
        @(negedge clk);
        hw_int_set = '0; hw_err_set = '0; hw_done_set = '0; hw_start_clr = '0;
    endtask

    task automatic t_reset();
        chk("R1", "eei", eei_o, '0);
        chk("R1", "int", int_o, '0);
        chk("R1", "err", err_o, '0);
        chk("R1", "start", start_o, '0);
        chk("R1", "done", done_o, '0);
        chk("R1", "pulses", pulses(), '0);
    endtask

    task automatic t_single();
        @(negedge clk);
        wr_en = 1'b1; cmd_sel = 4'd0; wr_data = 8'd3;
        #1 chk("R10", "eei before edge", eei_o, 16'h0000);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        chk("R3", "eei ch3 set", eei_o, 16'h0008);
        chk("R10", "eei_set pulse", eei_set_p, 16'h0008);
        @(negedge clk);
        chk("R10", "pulse gone", eei_set_p, 16'h0000);
        cmd(4'd0, 8'd15);
        chk("R3", "eei ch15 set", eei_o, 16'h8008);
        cmd(4'd1, 8'd3);
        chk("R6", "eei ch3 clear", eei_o, 16'h8000);
        chk("R6", "eei_clr pulse", eei_clr_p, 16'h0008);
        chk("R6", "start untouched", start_o, 16'h0000);
    endtask

    task automatic t_all();
        cmd(4'd0, 8'h40);
        chk("R5", "eei all set", eei_o, 16'hFFFF);
        cmd(4'd1, 8'h7F);
        chk("R5", "eei all clear", eei_o, 16'h0000);
        chk("R5", "clear pulse all", eei_clr_p, 16'hFFFF);
    endtask

    task automatic t_nop();
        cmd(4'd0, 8'h85);
        chk("R2", "nop single", eei_o, 16'h0000);
        chk("R2", "nop pulse", pulses(), 16'h0000);
        cmd(4'd0, 8'hC0);
        chk("R2", "nop all", eei_o, 16'h0000);
    endtask

    task automatic t_reserved();
        cmd(4'd0, 8'd16);
        chk("R4", "code 16", eei_o, 16'h0000);
        chk("R4", "code 16 pulse", pulses(), 16'h0000);
        cmd(4'd0, 8'd63);
        chk("R4", "code 63", eei_o, 16'h0000);
    endtask

    task automatic t_start_done();
        cmd(4'd4, 8'd7);
        chk("R6", "start ch7", start_o, 16'h0080);
        chk("R6", "start pulse", start_set_p, 16'h0080);
        hw(16'h0, 16'h0, 16'h00F0, 16'h0);
        chk("R11", "hw done set", done_o, 16'h00F0);
        cmd(4'd5, 8'd5);
        chk("R6", "done ch5 clear", done_o, 16'h00D0);
        hw(16'h0, 16'h0, 16'h0, 16'h0080);
        chk("R11", "hw start clear", start_o, 16'h0000);
    endtask

    task automatic t_int_err();
        hw(16'hFFFF, 16'hA5A5, 16'h0, 16'h0);
        chk("R11", "hw int set", int_o, 16'hFFFF);
        chk("R11", "hw err set", err_o, 16'hA5A5);
        cmd(4'd2, 8'd0);
        chk("R6", "int ch0 clear", int_o, 16'hFFFE);
        cmd(4'd3, 8'h40);
        chk("R6", "err all clear", err_o, 16'h0000);
        cmd(4'd6, 8'h0F);
        chk("R7", "int w1c low", int_o, 16'hFFF0);
        chk("R7", "int w1c low pulse", int_clr_p, 16'h000F);
        cmd(4'd7, 8'hF0);
        chk("R7", "int w1c high", int_o, 16'h0FF0);
        hw(16'h0, 16'hFFFF, 16'h0, 16'h0);
        cmd(4'd9, 8'h01);
        chk("R7", "err w1c high", err_o, 16'hFEFF);
        cmd(4'd8, 8'h80);
        chk("R7", "err w1c low", err_o, 16'hFE7F);
    endtask

    task automatic t_unused_sel();
        for (int s = 10; s < 16; s++) begin
            cmd(4'(s), 8'h40);
            chk("R8", "unused sel eei", eei_o, 16'h0000);
            chk("R8", "unused sel int", int_o, 16'h0FF0);
            chk("R8", "unused sel err", err_o, 16'hFE7F);
            chk("R8", "unused sel pulse", pulses(), 16'h0000);
        end
    endtask

    task automatic t_priority();
        cmd(4'd2, 8'd2, 16'h0004, 16'h0, 16'h0, 16'h0);
        chk("R9", "hw int set beats clear", int_o, 16'h0FF4);
        cmd(4'd3, 8'h40, 16'h0, 16'h0001, 16'h0, 16'h0);
        chk("R9", "hw err set beats clear all", err_o, 16'h0001);
        cmd(4'd4, 8'd1, 16'h0, 16'h0, 16'h0, 16'h0002);
        chk("R9", "start set beats hw clear", start_o, 16'h0002);
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_all();
        t_nop();
        t_reserved();
        t_start_done();
        t_int_err();
        t_unused_sel();
        t_priority();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule